// File: doc/BRIEF.md
# Prioritized Slot Interrupt Aggregator

This block collects seven active-low interrupt request lines from expansion slots and reduces them to one umbrella interrupt for the processor. A per-slot enable mask, written with a set/clear command word, decides which requests count. The masked, inverted request lines form a pending vector that software can read. A priority encoder names the highest-numbered pending slot, so a handler can serve slot 6 first and slot 0 last.

The umbrella flag records each new activity on the combined request line: the wired-OR of the enabled active-low lines falling, which is the OR of the pending bits rising. Software acknowledges the flag with a one-cycle clear strobe. If any slot is still pending when the flag is cleared, the flag is raised again at once. This means a request that arrives while software is servicing the flag is not lost. A compatibility mode models hosts that cannot mask slots one at a time. In that mode the umbrella output is held off whenever any slot is disabled.

No data stream passes through the block, so it has no valid/ready interface. Every pin is a plain control or status signal that is sampled or updated on each clock. No input applies back-pressure, and there is no handshake.

Top module: `slot_irq_agg`

## Requirements
- R1: `pending[i]` is 1 exactly when `slot_req_n[i]` is 0 and mask bit i is 1. It follows the request lines in the same cycle.
- R2: A write (`mask_wr` high) with `mask_wdata[7]` = 1 sets every mask bit i for which `mask_wdata[i]` = 1, for i in 0..6. All other mask bits keep their value. The new mask takes effect from the next cycle.
- R3: A write with `mask_wdata[7]` = 0 clears every mask bit i for which `mask_wdata[i]` = 1. All other mask bits keep their value.
- R4: After reset, all mask bits are 0. As a result, `pending` is 0, `prio_valid` is 0, and both `irq_flag` and `irq_out` are 0.
- R5: When the OR of `pending` goes from 0 to 1, `irq_flag` is 1 from the next cycle.
- R6: `irq_flag` stays set until a clear strobe, whether or not the requests go away. A further slot becoming pending while the flag is set does not change it.
- R7: A clear strobe (`flag_clr`) makes `irq_flag` equal, in the next cycle, to the OR of `pending` in the strobe cycle. The flag is re-raised if any slot is still pending and drops to 0 otherwise.
- R8: `prio_valid` equals the OR of `pending`. When it is 1, `prio_idx` is the highest bit number i for which `pending[i]` is 1, so bit 6 has the highest priority.
- R9: With `compat_mode` = 0, `irq_out` equals `irq_flag`. With `compat_mode` = 1, `irq_out` equals `irq_flag` only while all seven mask bits are 1, and is 0 otherwise.
- R10: A request on a masked slot does not appear in `pending` and does not set `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req_n | input | 7 | Slot request lines, active low, bit i = slot i |
| mask_wr | input | 1 | Mask command strobe |
| mask_wdata | input | 8 | Bit 7: 1 = set, 0 = clear; bits 6..0 select the slots |
| flag_clr | input | 1 | Umbrella flag clear strobe |
| compat_mode | input | 1 | 1 = umbrella output gated off while any slot is masked |
| pending | output | 7 | Masked pending slots |
| prio_valid | output | 1 | Some slot is pending |
| prio_idx | output | 3 | Highest pending slot number |
| irq_flag | output | 1 | Umbrella flag |
| irq_out | output | 1 | Umbrella interrupt after mode gating |

## Verification
A corrupted mask bit appears on `pending` in the first cycle in which that slot's line is driven low. The check drives each slot through set and clear commands and then asserts its request. A wrong edge-history register shows up on `irq_flag` one cycle after the pending set first becomes non-empty. It can also appear as a missing re-raise after a clear strobe, so both the first request and the clear-while-pending case are compared cycle by cycle. Encoder faults show up as a wrong `prio_idx` when several slots are pending together. Gating faults appear on `irq_out` as soon as one slot is masked in compatibility mode.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
  localparam int DEF_SLOTS = 7;

  typedef enum logic {
    MODE_NATIVE = 1'b0,
    MODE_COMPAT = 1'b1
  } umb_mode_e;
endpackage

// File: rtl/slot_mask_reg.sv
module slot_mask_reg #(
  parameter int NUM_SLOTS = slot_irq_pkg::DEF_SLOTS,
  localparam int CMD_W = NUM_SLOTS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [CMD_W-1:0]     wdata,
  output logic [NUM_SLOTS-1:0] mask
);
  logic                 set_op;
  logic [NUM_SLOTS-1:0] sel;

  assign set_op = wdata[CMD_W-1];
  assign sel    = wdata[NUM_SLOTS-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask <= '0;
    else if (wr) begin
      if (set_op) mask <= mask | sel;
      else        mask <= mask & ~sel;
    end
  end
endmodule

// File: rtl/slot_prio_enc.sv
module slot_prio_enc #(
  parameter int NUM_SLOTS = slot_irq_pkg::DEF_SLOTS,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] req,
  output logic                 valid,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
  assign valid = |req;
endmodule

// File: rtl/umbrella_flag.sv
module umbrella_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic clr,
  output logic flag
);
  logic any_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      any_q <= any_pend;
      if (clr)
        flag <= any_pend;
      else if (any_pend && !any_q)
        flag <= 1'b1;
    end
  end
endmodule

// File: rtl/slot_irq_agg.sv
module slot_irq_agg #(
  parameter int NUM_SLOTS = slot_irq_pkg::DEF_SLOTS,
  localparam int CMD_W = NUM_SLOTS + 1,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_req_n,
  input  logic                 mask_wr,
  input  logic [CMD_W-1:0]     mask_wdata,
  input  logic                 flag_clr,
  input  logic                 compat_mode,
  output logic [NUM_SLOTS-1:0] pending,
  output logic                 prio_valid,
  output logic [IDX_W-1:0]     prio_idx,
  output logic                 irq_flag,
  output logic                 irq_out
);
  import slot_irq_pkg::*;

  logic [NUM_SLOTS-1:0] mask;
  logic                 umb_enable;
  umb_mode_e            mode;

  slot_mask_reg #(.NUM_SLOTS(NUM_SLOTS)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .wdata(mask_wdata), .mask(mask)
  );

  assign pending = ~slot_req_n & mask;

  slot_prio_enc #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
    .req(pending), .valid(prio_valid), .idx(prio_idx)
  );

  umbrella_flag u_flag (
    .clk(clk), .rst_n(rst_n), .any_pend(|pending), .clr(flag_clr), .flag(irq_flag)
  );

  assign mode       = umb_mode_e'(compat_mode);
  assign umb_enable = (mode == MODE_COMPAT) ? &mask : 1'b1;
  assign irq_out    = irq_flag & umb_enable;
endmodule

// File: rtl/slot_irq_agg_chk.sv
module slot_irq_agg_chk #(
  parameter int NUM_SLOTS = 7,
  localparam int CMD_W = NUM_SLOTS + 1,
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] slot_req_n,
  input logic                 mask_wr,
  input logic [CMD_W-1:0]     mask_wdata,
  input logic                 flag_clr,
  input logic                 compat_mode,
  input logic [NUM_SLOTS-1:0] pending,
  input logic                 prio_valid,
  input logic [IDX_W-1:0]     prio_idx,
  input logic                 irq_flag,
  input logic                 irq_out
);
  // R1 / R10: only slots whose line is low can be pending
  a_r1_pend_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & slot_req_n) == '0);

  // R3: a cleared slot is not pending on the next cycle
  a_r3_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[CMD_W-1])
      |=> ((pending & $past(mask_wdata[NUM_SLOTS-1:0])) == '0));

  // R5: new pending activity raises the flag
  a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(|pending) && !flag_clr) |=> irq_flag);

  // R7: clear while something is still pending re-raises the flag
  a_r7_reraise: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && (|pending)) |=> irq_flag);

  // R8: encoder points at a pending slot with none higher
  a_r8_prio_top: assert property (@(posedge clk) disable iff (!rst_n)
    prio_valid |-> ((pending >> prio_idx) == NUM_SLOTS'(1)));

  // R9: the output is never active without the flag
  a_r9_out_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_flag);
endmodule

bind slot_irq_agg slot_irq_agg_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_req_n(slot_req_n), .mask_wr(mask_wr),
  .mask_wdata(mask_wdata), .flag_clr(flag_clr), .compat_mode(compat_mode),
  .pending(pending), .prio_valid(prio_valid), .prio_idx(prio_idx),
  .irq_flag(irq_flag), .irq_out(irq_out)
);

// File: tb/tb_slot_irq_agg.sv
module tb_slot_irq_agg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] slot_req_n = 7'h7F;
  logic       mask_wr = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       flag_clr = 1'b0;
  logic       compat_mode = 1'b0;
  logic [6:0] pending;
  logic       prio_valid;
  logic [2:0] prio_idx;
  logic       irq_flag;
  logic       irq_out;

  always #2 clk = ~clk;  // 250 MHz

  slot_irq_agg dut (.*);

  typedef struct {
    string      tag;
    logic [6:0] pend;
    logic       valid;
    logic [2:0] idx;
    logic       flag;
    logic       out;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // bench model state
  logic [6:0] m_mask = '0;
  logic       m_flag = 1'b0;
  logic       m_prev = 1'b0;

  function automatic logic [2:0] top_bit(logic [6:0] v);
    logic [2:0] r = '0;
    for (int i = 0; i < 7; i++) if (v[i]) r = 3'(i);
    return r;
  endfunction

  task automatic step(input logic [6:0] req, input logic wr, input logic [7:0] wd,
                      input logic clr, input logic cm, input string tag);
    exp_t e;
    logic [6:0] pnow;
    @(negedge clk);
    slot_req_n = req; mask_wr = wr; mask_wdata = wd; flag_clr = clr; compat_mode = cm;
    pnow = ~req & m_mask;
    if (clr) m_flag = |pnow;
    else if ((|pnow) && !m_prev) m_flag = 1'b1;
    m_prev = |pnow;
    if (wr) m_mask = wd[7] ? (m_mask | wd[6:0]) : (m_mask & ~wd[6:0]);
    e.tag   = tag;
    e.pend  = ~req & m_mask;
    e.valid = |e.pend;
    e.idx   = top_bit(e.pend);
    e.flag  = m_flag;
    e.out   = m_flag & (cm ? (&m_mask) : 1'b1);
    exp_q.push_back(e);
  endtask

  // monitor: compares one item per cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (pending !== e.pend || prio_valid !== e.valid ||
            (e.valid && prio_idx !== e.idx) || irq_flag !== e.flag || irq_out !== e.out) begin
          errors++;
          $display("FAIL %s: act pend=%h v=%b idx=%0d flag=%b out=%b exp pend=%h v=%b idx=%0d flag=%b out=%b",
                   e.tag, pending, prio_valid, prio_idx, irq_flag, irq_out,
                   e.pend, e.valid, e.idx, e.flag, e.out);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state, with requests asserted but nothing enabled
    slot_req_n = 7'h00;
    #1;
    checks++;
    if (pending !== 7'h00 || prio_valid !== 1'b0 || irq_flag !== 1'b0 || irq_out !== 1'b0) begin
      errors++;
      $display("FAIL R4: act pend=%h v=%b flag=%b out=%b exp 00 0 0 0",
               pending, prio_valid, irq_flag, irq_out);
    end
    step(7'h7F, 0, 8'h00, 0, 0, "R4 idle");
    // R10: masked request ignored
    step(7'h76, 0, 8'h00, 0, 0, "R10 masked req");
    step(7'h7F, 0, 8'h00, 0, 0, "R10 idle");
    // R2 set slots 0,3,6
    step(7'h7F, 1, 8'hC9, 0, 0, "R2 set");
    step(7'h77, 0, 8'h00, 0, 0, "R1 slot3 req");
    step(7'h77, 0, 8'h00, 0, 0, "R5 flag up");
    step(7'h36, 0, 8'h00, 0, 0, "R8 multi pending");
    step(7'h7F, 0, 8'h00, 0, 0, "R6 flag holds");
    step(7'h7E, 0, 8'h00, 0, 0, "R6 second req");
    step(7'h7E, 0, 8'h00, 1, 0, "R7 clear re-raise");
    step(7'h7F, 0, 8'h00, 0, 0, "R7 still set");
    step(7'h7F, 0, 8'h00, 1, 0, "R7 clear drops");
    step(7'h7F, 0, 8'h00, 0, 0, "R7 low");
    // R3 clear slot 6 and 0
    step(7'h7F, 1, 8'h41, 0, 0, "R3 clear");
    step(7'h3E, 0, 8'h00, 0, 0, "R3 cleared slot ignored");
    step(7'h36, 0, 8'h00, 0, 0, "R1 slot3");
    step(7'h36, 0, 8'h00, 0, 0, "R5 flag");
    // R9 compat with partial mask
    step(7'h36, 0, 8'h00, 0, 1, "R9 compat gated");
    step(7'h36, 1, 8'hFF, 0, 1, "R9 all enabled");
    step(7'h36, 0, 8'h00, 0, 1, "R9 compat open");
    step(7'h00, 0, 8'h00, 0, 1, "R8 all pending");
    step(7'h00, 1, 8'h10, 0, 1, "R9 one disabled");
    step(7'h00, 0, 8'h00, 0, 0, "R9 native");
    for (int i = 0; i < 7; i++) begin
      step(~(7'h01 << i), 0, 8'h00, 1, 0, "R8 single slot walk");
    end
    step(7'h7F, 0, 8'h00, 1, 0, "R7 final clear");
    step(7'h7F, 0, 8'h00, 0, 0, "R7 final idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: act timeout exp completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule